// File: doc/BRIEF.md
# Random Number Generator Register Front End

This block is the memory-mapped register face of a random number generator. A word source outside the block offers 32-bit random words, which the block queues in a small output FIFO. Software pops that FIFO by reading one address. It also writes a command register that requests self test or seed generation and triggers the clear-interrupt, clear-error and software-reset actions. A control register holds the empty-FIFO (underflow) policy, the auto-reseed enable and two interrupt masks. Software reads generator status, a set of sticky error flags and a constant version word.

Completion pulses and fault pulses come in from the generator's test logic, and the block turns them into sticky status bits, error flags and a single interrupt line. A read of the empty FIFO never returns stale data. What else it does depends on the underflow policy: it either flags an error, raises a bus error on that read, or raises the interrupt even when error interrupts are masked.

The bus is a simple request/response port. Every request, read or write, gets a response one clock later with data and an error bit. State changes from a request take effect on the same clock edge that produces the response.

Top module: `rng_bus_front`

## Requirements
- R1: Registers sit at byte offsets version 0x00, command 0x04, control 0x08, status 0x0C, error status 0x10 and FIFO data 0x14. Every request gets `rsp_valid` exactly one cycle later. A read of any other offset returns 0 with no bus error.
- R2: The version word holds the minor number in bits 7:0, the major number in bits 15:8 and the generator type in bits 31:28 (defaults 0x01, 0x02 and 0x1, giving 0x10000201). All other bits are 0, and writes to it are ignored.
- R3: Each read of 0x14 returns the oldest queued word and removes it. The FIFO holds 5 words, and a word offered while it is full is dropped. Status bits 11:8 give the fill level and bits 15:12 give the depth (5).
- R4: With control bits 1:0 at 00 or 01, a read of the empty FIFO returns 0, gives no bus error and sets error-status bit 4.
- R5: With control bits 1:0 at 10, a read of the empty FIFO returns 0 with `rsp_err` high. It leaves error-status bit 4 clear and does not raise the interrupt.
- R6: With control bits 1:0 at 11, a read of the empty FIFO returns 0 and raises the interrupt even when control bit 6 masks errors. Error-status bit 4 stays clear.
- R7: Command bit 0 (self-test request) and bit 1 (seed request) are stored, read back and drive `req_selftest` and `req_seed`. Command bits 4, 5 and 6 act when written as 1 and always read back as 0.
- R8: Control bits 1:0, 4, 5 and 6 are stored and read back, and all other control bits read 0. Bit 4 drives `cfg_autoreseed`.
- R9: Status bit 4 (self test done) and bit 5 (seed done) are set by `done_evt` bits 0 and 1 and stay set until reset. Bit 6 (new seed done) is set by `done_evt` bit 2 and cleared by clear-interrupt or clear-error. Bits 1, 2 and 3 follow `gen_busy`, `gen_sleep` and `gen_reseed`.
- R10: Error-status bits 3:0 are set by `fault_in` bits 3:0 (LFSR, oscillator, self test, statistical test) and are sticky. Status bit 16 is the OR of error-status bits 4:0.
- R11: The interrupt sets on any `done_evt` pulse while control bit 5 is 0, and on any fault or underflow flag while control bit 6 is 0. It holds until cleared, and it stays low while both masks are set.
- R12: Writing command bit 4 clears the interrupt. Writing bit 5 clears the error flags and the interrupt. A clear wins over a set arriving on the same cycle.
- R13: Writing command bit 6 empties the FIFO and clears the sticky status bits, the error flags, the interrupt and command bits 1:0 within one clock. The control register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Bus transfer error |
| word_valid | input | 1 | Random word offered |
| word_data | input | 32 | Random word |
| done_evt | input | 3 | Completion pulses: self test, seed, new seed |
| fault_in | input | 4 | Fault pulses: LFSR, oscillator, self test, statistics |
| gen_busy | input | 1 | Generator busy level |
| gen_sleep | input | 1 | Generator sleep level |
| gen_reseed | input | 1 | Reseed-needed level |
| req_selftest | output | 1 | Self-test request (command bit 0) |
| req_seed | output | 1 | Seed-generation request (command bit 1) |
| cfg_autoreseed | output | 1 | Auto-reseed enable (control bit 4) |
| irq | output | 1 | Interrupt line |

## Verification
A read response, and any FIFO pop, flag update or interrupt change caused by a request or a pulse input, happens on the clock edge that samples the stimulus. The results are therefore visible one cycle after the input is driven. The bench drives each stimulus on a falling edge, waits for the next rising edge, and samples one time unit later. A status read issued in the following cycle then sees the updated level, flags and sticky bits. The interrupt line is compared against the bench model after every single-cycle operation, and same-cycle collisions of a clear with a fault are driven on purpose.

// File: rtl/rng_front_pkg.sv
package rng_front_pkg;

  localparam int REG_W   = 32;
  localparam int ADDR_W  = 5;
  localparam int FLT_W   = 4;
  localparam int EVT_W   = 3;

  localparam logic [ADDR_W-1:0] OFF_VER  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_ERR  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_DATA = 5'h14;

  typedef enum logic [1:0] {
    UF_ZERO_FLAG  = 2'b00,
    UF_ZERO_FLAG2 = 2'b01,
    UF_BUS_ERR    = 2'b10,
    UF_FORCE_IRQ  = 2'b11
  } uf_mode_e;

  typedef struct packed {
    logic     mask_err;
    logic     mask_done;
    logic     auto_reseed;
    uf_mode_e uf_mode;
  } ctrl_t;

endpackage

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  AST_FIFO_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst) level <= LVL_W'(DEPTH)); // R3
  AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst) full && !pop && !flush |=> full); // R3
  AST_FIFO_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush |=> empty); // R13

endmodule

// File: rtl/rng_event_core.sv
module rng_event_core #(
  parameter int FLT_W = 4,
  parameter int EVT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             clr_irq,
  input  logic             clr_err,
  input  logic             mask_done,
  input  logic             mask_err,
  input  logic [EVT_W-1:0] evt_in,
  input  logic [FLT_W-1:0] fault_in,
  input  logic             uf_flag,
  input  logic             uf_irq,
  output logic [FLT_W:0]   err_flags,
  output logic             st_done,
  output logic             seed_done,
  output logic             nseed_done,
  output logic             irq
);

  logic any_clear, done_hit, err_hit;

  assign any_clear = clr_irq || clr_err;
  assign done_hit  = (|evt_in) && !mask_done;
  assign err_hit   = ((|fault_in) || uf_flag) && !mask_err;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      err_flags  <= '0;
      st_done    <= 1'b0;
      seed_done  <= 1'b0;
      nseed_done <= 1'b0;
      irq        <= 1'b0;
    end else begin
      st_done   <= st_done   | evt_in[0];
      seed_done <= seed_done | evt_in[1];
      if (clr_err) err_flags <= '0;
      else         err_flags <= err_flags | {uf_flag, fault_in};
      if (any_clear) nseed_done <= 1'b0;
      else           nseed_done <= nseed_done | evt_in[2];
      if (any_clear)                        irq <= 1'b0;
      else if (done_hit || err_hit || uf_irq) irq <= 1'b1;
    end
  end

  AST_IRQ_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) (any_clear || soft_rst) |=> !irq); // R12
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) st_done && !soft_rst |=> st_done); // R9
  AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (rst) !irq && mask_done && mask_err && !uf_irq |=> !irq); // R11
  AST_UF_FORCES_IRQ: assert property (@(posedge clk) disable iff (rst) uf_irq && !any_clear && !soft_rst |=> irq); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) (err_flags != '0) && !clr_err && !soft_rst |=> (err_flags != '0)); // R10

endmodule

// File: rtl/rng_bus_front.sv
module rng_bus_front
  import rng_front_pkg::*;
#(
  parameter int         FIFO_DEPTH = 5,
  parameter logic [7:0] VER_MINOR  = 8'h01,
  parameter logic [7:0] VER_MAJOR  = 8'h02,
  parameter logic [3:0] GEN_TYPE   = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [4:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              word_valid,
  input  logic [31:0]       word_data,
  input  logic [2:0]        done_evt,
  input  logic [3:0]        fault_in,
  input  logic              gen_busy,
  input  logic              gen_sleep,
  input  logic              gen_reseed,
  output logic              req_selftest,
  output logic              req_seed,
  output logic              cfg_autoreseed,
  output logic              irq
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [3:0] SIZE_FIELD = 4'(FIFO_DEPTH);

  ctrl_t              ctrl_q;
  logic               cmd_st_q, cmd_gs_q;
  logic               rd_en, wr_en, fifo_rd, cmd_wr;
  logic               soft_rst, clr_irq, clr_err;
  logic               uf_flag, uf_irq, uf_buserr;
  logic [REG_W-1:0]   fifo_head, rd_word;
  logic [LVL_W-1:0]   fifo_level;
  logic               fifo_empty;
  logic [FLT_W:0]     err_flags;
  logic               st_done, seed_done, nseed_done;
  logic               unused_wbits;

  assign unused_wbits = ^{req_wdata[31:7], req_wdata[3:2]};

  // request decode
  assign rd_en   = req_valid && !req_write;
  assign wr_en   = req_valid && req_write;
  assign fifo_rd = rd_en && (req_addr == OFF_DATA);
  assign cmd_wr  = wr_en && (req_addr == OFF_CMD);
  assign soft_rst = cmd_wr && req_wdata[6];
  assign clr_err  = cmd_wr && req_wdata[5];
  assign clr_irq  = cmd_wr && req_wdata[4];

  // underflow policy
  always_comb begin
    uf_flag   = 1'b0;
    uf_irq    = 1'b0;
    uf_buserr = 1'b0;
    if (fifo_rd && fifo_empty) begin
      unique case (ctrl_q.uf_mode)
        UF_BUS_ERR:   uf_buserr = 1'b1;
        UF_FORCE_IRQ: uf_irq    = 1'b1;
        default:      uf_flag   = 1'b1;
      endcase
    end
  end

  rng_word_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (soft_rst),
    .push      (word_valid),
    .push_data (word_data),
    .pop       (fifo_rd),
    .head      (fifo_head),
    .level     (fifo_level),
    .empty     (fifo_empty)
  );

  rng_event_core #(.FLT_W(FLT_W), .EVT_W(EVT_W)) u_events (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .clr_irq    (clr_irq),
    .clr_err    (clr_err),
    .mask_done  (ctrl_q.mask_done),
    .mask_err   (ctrl_q.mask_err),
    .evt_in     (done_evt),
    .fault_in   (fault_in),
    .uf_flag    (uf_flag),
    .uf_irq     (uf_irq),
    .err_flags  (err_flags),
    .st_done    (st_done),
    .seed_done  (seed_done),
    .nseed_done (nseed_done),
    .irq        (irq)
  );

  // command and control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_st_q <= 1'b0;
      cmd_gs_q <= 1'b0;
      ctrl_q   <= '0;
    end else begin
      if (soft_rst) begin
        cmd_st_q <= 1'b0;
        cmd_gs_q <= 1'b0;
      end else if (cmd_wr) begin
        cmd_st_q <= req_wdata[0];
        cmd_gs_q <= req_wdata[1];
      end
      if (wr_en && (req_addr == OFF_CTRL)) begin
        ctrl_q.mask_err    <= req_wdata[6];
        ctrl_q.mask_done   <= req_wdata[5];
        ctrl_q.auto_reseed <= req_wdata[4];
        ctrl_q.uf_mode     <= uf_mode_e'(req_wdata[1:0]);
      end
    end
  end

  // read mux
  always_comb begin
    rd_word = '0;
    unique case (req_addr)
      OFF_VER:  rd_word = {GEN_TYPE, 12'h000, VER_MAJOR, VER_MINOR};
      OFF_CMD:  rd_word = {30'b0, cmd_gs_q, cmd_st_q};
      OFF_CTRL: rd_word = {25'b0, ctrl_q.mask_err, ctrl_q.mask_done,
                           ctrl_q.auto_reseed, 2'b00, ctrl_q.uf_mode};
      OFF_STAT: rd_word = {15'b0, |err_flags, SIZE_FIELD, 4'(fifo_level), 1'b0,
                           nseed_done, seed_done, st_done, gen_reseed,
                           gen_sleep, gen_busy, 1'b0};
      OFF_ERR:  rd_word = {{(REG_W-FLT_W-1){1'b0}}, err_flags};
      OFF_DATA: rd_word = fifo_empty ? '0 : fifo_head;
      default:  rd_word = '0;
    endcase
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (rd_en && !uf_buserr) ? rd_word : '0;
      rsp_err   <= uf_buserr;
    end
  end

  assign req_selftest   = cmd_st_q;
  assign req_seed       = cmd_gs_q;
  assign cfg_autoreseed = ctrl_q.auto_reseed;

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R1
  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R1
  AST_BUSERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst) rsp_err |-> (rsp_rdata == '0) && rsp_valid); // R5
  AST_CTRL_KEPT_ON_SRST: assert property (@(posedge clk) disable iff (rst) soft_rst |=> $stable(ctrl_q)); // R13

endmodule

// File: tb/rng_bus_front_test.sv
module rng_bus_front_test;

  localparam int CLK_T = 10;
  localparam logic [4:0] A_VER = 5'h00, A_CMD = 5'h04, A_CTRL = 5'h08,
                         A_STAT = 5'h0C, A_ERR = 5'h10, A_DATA = 5'h14;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [4:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic word_valid = 0;
  logic [31:0] word_data = 0;
  logic [2:0] done_evt = 0;
  logic [3:0] fault_in = 0;
  logic gen_busy = 0, gen_sleep = 0, gen_reseed = 0;
  logic req_selftest, req_seed, cfg_autoreseed, irq;

  int unsigned n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_T/2) clk = ~clk;

  rng_bus_front uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .word_valid(word_valid),
    .word_data(word_data), .done_evt(done_evt), .fault_in(fault_in),
    .gen_busy(gen_busy), .gen_sleep(gen_sleep), .gen_reseed(gen_reseed),
    .req_selftest(req_selftest), .req_seed(req_seed),
    .cfg_autoreseed(cfg_autoreseed), .irq(irq)
  );

  // bench model
  logic [31:0] m_q [5];
  int m_cnt;
  logic [4:0] m_err;
  logic m_irq, m_std, m_sd, m_nsd, m_st, m_gs;
  logic [1:0] m_uf;
  logic m_ar, m_md, m_me;

  function automatic logic [31:0] exp_status();
    return {15'b0, |m_err, 4'd5, 4'(m_cnt), 1'b0, m_nsd, m_sd, m_std,
            gen_reseed, gen_sleep, gen_busy, 1'b0};
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return {25'b0, m_me, m_md, m_ar, 2'b00, m_uf};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear_all();
    m_cnt = 0; m_err = 0; m_irq = 0; m_std = 0; m_sd = 0; m_nsd = 0;
    m_st = 0; m_gs = 0;
  endtask

  task automatic model_cmd(input logic [31:0] d);
    if (d[6]) model_clear_all();
    else begin
      m_st = d[0]; m_gs = d[1];
      if (d[5]) begin m_err = 0; m_irq = 0; m_nsd = 0; end
      if (d[4]) begin m_irq = 0; m_nsd = 0; end
    end
  endtask

  task automatic bus_cycle(input logic wr, input logic [4:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output logic e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata; e = rsp_err;
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] rd; logic e;
    bus_cycle(1'b1, a, d, rd, e);
    if (a == A_CMD) model_cmd(d);
    if (a == A_CTRL) begin m_uf = d[1:0]; m_ar = d[4]; m_md = d[5]; m_me = d[6]; end
    chk("R7 cmd outputs", {30'b0, req_seed, req_selftest}, {30'b0, m_gs, m_st});
    chk("R8 autoreseed out", {31'b0, cfg_autoreseed}, {31'b0, m_ar});
    chk("R11 irq after write", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic bus_rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic e;
    bus_cycle(1'b0, a, 32'h0, rd, e);
    chk(tag, rd, exp);
    chk({tag, " err"}, {31'b0, e}, 32'd0);
  endtask

  task automatic rd_fifo();
    logic [31:0] rd, exp; logic e, exp_e; string tag;
    exp_e = 0; exp = 0;
    if (m_cnt > 0) begin
      tag = "R3 fifo pop";
      exp = m_q[0];
      for (int i = 0; i < 4; i++) m_q[i] = m_q[i+1];
      m_cnt--;
    end else begin
      case (m_uf)
        2'b10: begin tag = "R5 underflow buserr"; exp_e = 1; end
        2'b11: begin tag = "R6 underflow irq"; m_irq = 1; end
        default: begin tag = "R4 underflow flag"; m_err[4] = 1; if (!m_me) m_irq = 1; end
      endcase
    end
    bus_cycle(1'b0, A_DATA, 32'h0, rd, e);
    chk(tag, rd, exp);
    chk({tag, " err"}, {31'b0, e}, {31'b0, exp_e});
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); word_valid = 1; word_data = w;
    @(posedge clk); #1; word_valid = 0;
    if (m_cnt < 5) begin m_q[m_cnt] = w; m_cnt++; end
  endtask

  task automatic pulse_evt(input logic [2:0] ev);
    @(negedge clk); done_evt = ev;
    @(posedge clk); #1; done_evt = 0;
    m_std |= ev[0]; m_sd |= ev[1]; m_nsd |= ev[2];
    if (ev != 0 && !m_md) m_irq = 1;
    chk("R11 irq after done event", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic pulse_flt(input logic [3:0] f);
    @(negedge clk); fault_in = f;
    @(posedge clk); #1; fault_in = 0;
    m_err[3:0] |= f;
    if (f != 0 && !m_me) m_irq = 1;
    chk("R11 irq after fault", {31'b0, irq}, {31'b0, m_irq});
  endtask

  initial begin
    #(CLK_T * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'd4711);
    model_clear_all();
    m_uf = 0; m_ar = 0; m_md = 0; m_me = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // reset state and map
    bus_rd_chk("R2 version", A_VER, 32'h1000_0201);
    bus_rd_chk("R7 cmd reset", A_CMD, 32'h0);
    bus_rd_chk("R8 ctrl reset", A_CTRL, 32'h0);
    bus_rd_chk("R3 status reset", A_STAT, exp_status());
    bus_rd_chk("R10 errstat reset", A_ERR, 32'h0);
    bus_rd_chk("R1 unmapped 0x18", 5'h18, 32'h0);
    bus_rd_chk("R1 unmapped 0x1C", 5'h1C, 32'h0);
    chk("R11 irq reset", {31'b0, irq}, 32'd0);

    // version is read-only
    bus_wr(A_VER, 32'hFFFF_FFFF);
    bus_rd_chk("R2 version after write", A_VER, 32'h1000_0201);

    // command write-only bits
    bus_wr(A_CMD, 32'h0000_0033);
    bus_rd_chk("R7 cmd readback", A_CMD, 32'h3);
    bus_wr(A_CMD, 32'h0);

    // control readback
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    bus_rd_chk("R8 ctrl readback", A_CTRL, 32'h73);
    bus_wr(A_CTRL, 32'h0);

    // FIFO order, depth, drop when full
    for (int i = 0; i < 6; i++) push(32'hA000_0000 + i);
    bus_rd_chk("R3 level full", A_STAT, exp_status());
    for (int i = 0; i < 5; i++) rd_fifo();
    rd_fifo();
    bus_rd_chk("R4 errstat bit4", A_ERR, 32'h10);
    bus_rd_chk("R10 summary error", A_STAT, exp_status());
    bus_wr(A_CMD, 32'h20);
    bus_rd_chk("R12 errors cleared", A_ERR, 32'h0);

    // bus error policy
    bus_wr(A_CTRL, 32'h2);
    rd_fifo();
    bus_rd_chk("R5 no flag", A_ERR, 32'h0);

    // forced interrupt policy with errors masked
    bus_wr(A_CTRL, 32'h43);
    rd_fifo();
    bus_rd_chk("R6 no flag", A_ERR, 32'h0);
    bus_wr(A_CMD, 32'h10);

    // masks
    bus_wr(A_CTRL, 32'h60);
    pulse_evt(3'b111);
    pulse_flt(4'b0101);
    bus_rd_chk("R10 fault flags", A_ERR, 32'h05);
    bus_rd_chk("R9 done bits", A_STAT, exp_status());
    bus_wr(A_CTRL, 32'h20);
    pulse_flt(4'b1000);
    bus_wr(A_CMD, 32'h10);
    bus_rd_chk("R9 sticky after clear", A_STAT, exp_status());

    // clear wins over same-cycle fault
    @(negedge clk);
    fault_in = 4'b0010; req_valid = 1; req_write = 1; req_addr = A_CMD; req_wdata = 32'h20;
    @(posedge clk); #1;
    fault_in = 0; req_valid = 0; req_write = 0;
    m_err = 0; m_irq = 0; m_nsd = 0; m_st = 0; m_gs = 0;
    chk("R12 clear wins irq", {31'b0, irq}, 32'd0);
    bus_rd_chk("R12 clear wins flags", A_ERR, 32'h0);

    // status mirrors
    gen_busy = 1; gen_sleep = 0; gen_reseed = 1;
    bus_rd_chk("R9 mirror", A_STAT, exp_status());
    gen_busy = 0; gen_reseed = 0;

    // software reset
    bus_wr(A_CTRL, 32'h11);
    push(32'h1111_2222); push(32'h3333_4444);
    pulse_flt(4'b0001);
    pulse_evt(3'b011);
    bus_wr(A_CMD, 32'h43);
    chk("R13 irq cleared", {31'b0, irq}, 32'd0);
    bus_rd_chk("R13 status cleared", A_STAT, exp_status());
    bus_rd_chk("R13 errors cleared", A_ERR, 32'h0);
    bus_rd_chk("R13 ctrl kept", A_CTRL, 32'h11);
    bus_rd_chk("R13 cmd cleared", A_CMD, 32'h0);
    rd_fifo();

    // random phase
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom_range(0, 10);
      case (op)
        0, 1: push($urandom);
        2, 3: rd_fifo();
        4: bus_rd_chk("R9 status random", A_STAT, exp_status());
        5: bus_rd_chk("R10 errstat random", A_ERR, {27'b0, m_err});
        6: pulse_evt(3'($urandom_range(1, 7)));
        7: pulse_flt(4'($urandom_range(0, 15)));
        8: bus_wr(A_CTRL, $urandom);
        9: begin
          int unsigned r;
          logic [31:0] d;
          r = $urandom_range(0, 9);
          d = $urandom & 32'h3;
          if (r >= 4 && r < 7) d = d | 32'h10;
          else if (r >= 7 && r < 9) d = 32'h20;
          else if (r == 9) d = 32'h40;
          bus_wr(A_CMD, d);
        end
        default: begin
          gen_busy = 1'($urandom); gen_sleep = 1'($urandom); gen_reseed = 1'($urandom);
          bus_rd_chk("R8 ctrl random", A_CTRL, exp_ctrl());
        end
      endcase
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule